// File: doc/BRIEF.md
# Nibble-Serial Phase Interpolator with Sine/Cosine Output

The block keeps a 12-bit phase accumulator and, on each start request, adds a signed 8-bit increment to it using a single 4-bit adder with a carry flop. The addition runs over three consecutive clocks. The low nibble goes first. The middle nibble follows, with the carry from the low nibble. The top nibble comes last, where the increment's sign bit is replicated across the whole adder operand. Only one accumulator nibble is written per clock.

After the third subcycle the accumulator is frozen. Its upper eight bits address a waveform lookup that returns either a sine or a cosine sample in offset-binary form. That lookup is built from two 4-bit slices: one drives the upper half of the DAC word and the other drives the lower half. The result is registered onto the DAC output, and a one-clock valid pulse marks each update.

The increment is loaded a nibble at a time through a small write port with four holding registers. An external controller loads the increment, selects sine or cosine, and pulses start.

Top module: `phase_interp_dac`

## Requirements
- R1: When `wr_ni` is low at a clock edge, `wdata_i` is stored in the holding register addressed by `waddr_i`. Register 0 is the low nibble of the increment and register 1 is the high nibble. Together they form an 8-bit two's-complement increment with bit 7 as the sign. Registers 2 and 3 can be written but have no effect on any output.
- R2: A high `start_i` sampled while idle begins a cycle. `busy_o` is high for exactly four clocks after that edge.
- R3: A `start_i` pulse that arrives while `busy_o` is high is ignored and produces no extra update.
- R4: Each cycle adds the sign-extended increment to the 12-bit accumulator modulo 4096. The accumulator resets to zero.
- R5: The addition is nibble-serial: low, then middle, then top, one accumulator nibble per clock. The carry is chained between subcycles, and the carry into the low nibble is zero.
- R6: The accumulator holds its value while idle and during the lookup clock.
- R7: The lookup phase is accumulator bits [11:4]; the lowest nibble is discarded.
- R8: With `cos_sel_i` low, for phase p let h = p[6:0] and y = min((h*(128-h)) >> 5, 127). `dac_o` is 128+y when p[7]=0 and 128-y when p[7]=1.
- R9: With `cos_sel_i` high (sampled at the edge that updates `dac_o`), the output is the R8 value for phase (p+64) mod 256.
- R10: `dac_o` changes only on the fourth edge after the start edge. On that edge `valid_o` goes high for one clock and `busy_o` falls. Between updates `dac_o` holds its value.
- R11: While reset is asserted, `dac_o` is 0 and both `busy_o` and `valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_ni | input | 1 | Holding-register write strobe, active low |
| waddr_i | input | 2 | Holding-register address |
| wdata_i | input | 4 | Holding-register write data |
| start_i | input | 1 | Begin an accumulate-and-lookup cycle |
| cos_sel_i | input | 1 | 1 selects cosine, 0 selects sine |
| dac_o | output | 8 | Offset-binary waveform sample |
| busy_o | output | 1 | Cycle in progress |
| valid_o | output | 1 | One-clock pulse when `dac_o` updates |

## Verification
The embedded assertions check on every cycle the following properties:
- At most one accumulator nibble is write-enabled.
- The low-nibble subcycle adds with zero carry-in.
- The accumulator stays frozen while idle and during the lookup.
- Holding registers change only under a low write strobe.
- The DAC word moves only with a single-clock valid pulse.

The bench scenarios demonstrate the arithmetic end to end:
- Wrap-around of negative increments.
- Carries that ripple across nibbles.
- Discarding of the low nibble, shown by sixteen unit steps that move the phase once.
- The sine and cosine values.
- Starts ignored while busy.
- Writes to the unused registers having no effect.

// File: rtl/interp_pkg.sv
package interp_pkg;
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned ACC_NIBS = 3;
  localparam int unsigned N_REGS   = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADD  = 2'd1,
    SEQ_LOOK = 2'd2
  } seq_state_e;
endpackage

// File: rtl/interp_regfile.sv
module interp_regfile #(
  parameter  int unsigned NIB_W  = interp_pkg::NIB_W,
  parameter  int unsigned N_REGS = interp_pkg::N_REGS,
  localparam int unsigned SEL_W  = $clog2(N_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ni,
  input  logic [SEL_W-1:0] waddr_i,
  input  logic [NIB_W-1:0] wdata_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [NIB_W-1:0] rd_data_o
);
  logic [N_REGS-1:0][NIB_W-1:0] regs_q;

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[r] <= '0;
      else if (!wr_ni && waddr_i == SEL_W'(r)) regs_q[r] <= wdata_i;
    end
  end

  assign rd_data_o = regs_q[rd_sel_i];

  // R1: holding registers change only under a low strobe
  assert_regs_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ni |=> $stable(regs_q));
endmodule

// File: rtl/interp_nib_add.sv
module interp_nib_add #(
  parameter int unsigned NIB_W = interp_pkg::NIB_W
) (
  input  logic [NIB_W-1:0] a_i,
  input  logic [NIB_W-1:0] b_i,
  input  logic             c_i,
  output logic [NIB_W-1:0] s_o,
  output logic             c_o
);
  logic [NIB_W:0] full;
  assign full = {1'b0, a_i} + {1'b0, b_i} + {{NIB_W{1'b0}}, c_i};
  assign s_o  = full[NIB_W-1:0];
  assign c_o  = full[NIB_W];
endmodule

// File: rtl/interp_accum.sv
module interp_accum
  import interp_pkg::*;
#(
  parameter  int unsigned NIB_W    = interp_pkg::NIB_W,
  parameter  int unsigned ACC_NIBS = interp_pkg::ACC_NIBS,
  parameter  int unsigned N_REGS   = interp_pkg::N_REGS,
  localparam int unsigned IDX_W    = $clog2(ACC_NIBS),
  localparam int unsigned SEL_W    = $clog2(N_REGS),
  localparam int unsigned ACC_W    = NIB_W * ACC_NIBS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NIB_W-1:0] inc_nib_i,
  output logic [SEL_W-1:0] rd_sel_o,
  output logic [ACC_W-1:0] acc_o,
  output logic             busy_o,
  output logic             look_o
);
  seq_state_e                     state_q;
  logic [IDX_W-1:0]               idx_q;
  logic [ACC_NIBS-1:0][NIB_W-1:0] acc_q;
  logic [ACC_NIBS-1:0]            we_n;
  logic                           carry_q, cin, cout, top;
  logic [NIB_W-1:0]               op_a, op_b, sum;

  assign top      = (idx_q == IDX_W'(ACC_NIBS - 1));
  // top subcycle keeps the last increment register selected and uses its sign
  assign rd_sel_o = top ? SEL_W'(ACC_NIBS - 2) : SEL_W'(idx_q);
  assign op_a     = acc_q[idx_q];
  assign op_b     = top ? {NIB_W{inc_nib_i[NIB_W-1]}} : inc_nib_i;
  assign cin      = (idx_q != '0) && carry_q;

  interp_nib_add #(.NIB_W(NIB_W)) u_add (
    .a_i(op_a), .b_i(op_b), .c_i(cin), .s_o(sum), .c_o(cout)
  );

  for (genvar k = 0; k < ACC_NIBS; k++) begin : g_nib
    logic [NIB_W-1:0] nib_q;
    assign we_n[k] = !(state_q == SEQ_ADD && idx_q == IDX_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       nib_q <= '0;
      else if (!we_n[k]) nib_q <= sum;
    end
    assign acc_q[k] = nib_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_ADD;
          idx_q   <= '0;
        end
        SEQ_ADD: begin
          carry_q <= cout;
          if (top) state_q <= SEQ_LOOK;
          else     idx_q   <= idx_q + 1'b1;
        end
        SEQ_LOOK: state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign acc_o  = acc_q;
  assign busy_o = (state_q != SEQ_IDLE);
  assign look_o = (state_q == SEQ_LOOK);

  // R5: one nibble written per clock
  assert_one_nib_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~we_n));
  // R5: low nibble adds with zero carry-in
  assert_low_nib_sum_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_ADD && idx_q == '0) |=>
      acc_q[0] == NIB_W'($past(acc_q[0]) + $past(inc_nib_i)));
  // R6: accumulator frozen while idle and during lookup
  assert_acc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SEQ_ADD) |=> $stable(acc_q));
endmodule

// File: rtl/interp_wave_slice.sv
module interp_wave_slice #(
  parameter int unsigned PH_W  = 8,
  parameter int unsigned NIB_W = interp_pkg::NIB_W,
  parameter int unsigned SLICE = 0
) (
  input  logic [PH_W-1:0]  phase_i,
  input  logic             cos_i,
  output logic [NIB_W-1:0] nib_o
);
  localparam int HALF = 2 ** (PH_W - 1);
  localparam int QTR  = 2 ** (PH_W - 2);

  function automatic logic [PH_W-1:0] wave(logic [PH_W-1:0] p);
    int h, y;
    h = int'(p[PH_W-2:0]);
    y = (h * (HALF - h)) >>> (PH_W - 3);
    if (y > HALF - 1) y = HALF - 1;
    if (p[PH_W-1]) return PH_W'(HALF - y);
    else           return PH_W'(HALF + y);
  endfunction

  logic [PH_W-1:0] p_eff, full;
  assign p_eff = phase_i + (cos_i ? PH_W'(QTR) : '0);
  assign full  = wave(p_eff);
  assign nib_o = full[SLICE*NIB_W +: NIB_W];
endmodule

// File: rtl/phase_interp_dac.sv
module phase_interp_dac
  import interp_pkg::*;
#(
  parameter  int unsigned NIB_W    = interp_pkg::NIB_W,
  parameter  int unsigned ACC_NIBS = interp_pkg::ACC_NIBS,
  parameter  int unsigned N_REGS   = interp_pkg::N_REGS,
  localparam int unsigned SEL_W    = $clog2(N_REGS),
  localparam int unsigned ACC_W    = NIB_W * ACC_NIBS,
  localparam int unsigned DAC_W    = NIB_W * (ACC_NIBS - 1),
  localparam int unsigned N_SLICE  = DAC_W / NIB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ni,
  input  logic [SEL_W-1:0] waddr_i,
  input  logic [NIB_W-1:0] wdata_i,
  input  logic             start_i,
  input  logic             cos_sel_i,
  output logic [DAC_W-1:0] dac_o,
  output logic             busy_o,
  output logic             valid_o
);
  logic [SEL_W-1:0] rd_sel;
  logic [NIB_W-1:0] inc_nib;
  logic [ACC_W-1:0] acc;
  logic             look;
  logic [DAC_W-1:0] wave_w, dac_q;
  logic             valid_q;

  interp_regfile #(.NIB_W(NIB_W), .N_REGS(N_REGS)) u_regs (
    .clk_i, .rst_ni, .wr_ni, .waddr_i, .wdata_i,
    .rd_sel_i(rd_sel), .rd_data_o(inc_nib)
  );

  interp_accum #(.NIB_W(NIB_W), .ACC_NIBS(ACC_NIBS), .N_REGS(N_REGS)) u_acc (
    .clk_i, .rst_ni, .start_i, .inc_nib_i(inc_nib),
    .rd_sel_o(rd_sel), .acc_o(acc), .busy_o, .look_o(look)
  );

  // lowest accumulator nibble is dropped from the phase
  for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
    interp_wave_slice #(.PH_W(DAC_W), .NIB_W(NIB_W), .SLICE(s)) u_tab (
      .phase_i(acc[ACC_W-1:NIB_W]), .cos_i(cos_sel_i),
      .nib_o(wave_w[s*NIB_W +: NIB_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= look;
      if (look) dac_q <= wave_w;
    end
  end

  assign dac_o   = dac_q;
  assign valid_o = valid_q;

  // R10: valid is a single-clock pulse
  assert_valid_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R10: output word moves only together with valid
  assert_dac_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(dac_o));
endmodule

// File: tb/phase_interp_dac_tb.sv
`timescale 1ns/1ps
module phase_interp_dac_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_n = 1'b1;
  logic [1:0] waddr = '0;
  logic [3:0] wdata = '0;
  logic       start = 1'b0;
  logic       cos_sel = 1'b0;
  logic [7:0] dac;
  logic       busy, valid;

  always #4 clk = ~clk;

  phase_interp_dac u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_ni(wr_n), .waddr_i(waddr), .wdata_i(wdata),
    .start_i(start), .cos_sel_i(cos_sel), .dac_o(dac), .busy_o(busy), .valid_o(valid)
  );

  int    n_cmp = 0, n_bad = 0, n_valid = 0, n_push = 0;
  int    acc_m = 0;
  int    exp_q[$];
  string tag_q[$];
  int    last_exp = 0;

  function automatic int wave_m(int p);
    int h, y;
    h = p % 128;
    y = (h * (128 - h)) / 32;
    if (y > 127) y = 127;
    return (p >= 128) ? 128 - y : 128 + y;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_n = 1'b0; waddr = 2'(a); wdata = 4'(d);
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  // driver: loads increment, predicts result, starts the cycle
  task automatic run(int inc, bit cs, string tag, bit poke);
    int s, p, nb;
    wr(0, inc & 15);
    wr(1, (inc >> 4) & 15);
    s = (inc >= 128) ? inc - 256 : inc;
    acc_m = (acc_m + s) & 12'hFFF;
    p = ((acc_m >> 4) + (cs ? 64 : 0)) & 255;
    last_exp = wave_m(p);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
    n_push++;
    @(negedge clk);
    cos_sel = cs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nb = 0;
    while (busy && nb < 20) begin
      nb++;
      start = (poke && nb == 2);
      @(negedge clk);
    end
    start = 1'b0;
    check("R2 busy length", nb, 4);
    check("R10 valid at busy fall", int'(valid), 1);
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n && valid) begin
      n_valid++;
      if (exp_q.size() == 0) begin
        n_bad++; n_cmp++;
        $display("FAIL R3 unexpected update actual=%0h expected=none", dac);
      end else begin
        check(tag_q.pop_front(), int'(dac), exp_q.pop_front());
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 dac reset", int'(dac), 0);
    check("R11 busy reset", int'(busy), 0);
    check("R11 valid reset", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: unit steps sit in the discarded nibble until the 16th
    for (int i = 0; i < 16; i++) run(1, 1'b0, "R7 unit step", 1'b0);
    // R8: sine across phases
    for (int i = 0; i < 6; i++) run(8'h70, 1'b0, "R8 sine", 1'b0);
    // R9: cosine
    for (int i = 0; i < 4; i++) run(8'h35, 1'b1, "R9 cosine", 1'b0);
    // R4: negative increments wrap below zero
    for (int i = 0; i < 8; i++) run(8'h80, 1'b0, "R4 negative wrap", 1'b0);
    // R5: carries rippling through middle and top nibbles
    run(8'h0F, 1'b0, "R5 carry", 1'b0);
    run(8'h7F, 1'b0, "R5 carry", 1'b0);
    run(8'hFF, 1'b1, "R5 borrow", 1'b0);
    // R1: unused registers do not alter the result
    wr(2, 4'hF);
    wr(3, 4'hA);
    run(8'h21, 1'b0, "R1 unused regs", 1'b0);
    // R3: start while busy ignored
    run(8'h44, 1'b0, "R3 poke", 1'b1);
    repeat (8) @(negedge clk);
    check("R3 update count", n_valid, n_push);
    // R6/R10: output and phase held through idle time
    check("R10 dac hold", int'(dac), last_exp);
    repeat (20) @(negedge clk);
    run(8'h00, 1'b0, "R6 idle hold", 1'b0);
    repeat (4) @(negedge clk);
    check("R10 queue drained", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule